// File: doc/BRIEF.md
# Issue Queue with Tag Wakeup

This block holds a small pool of renamed instructions that wait for their operands in an out-of-order core. Each slot keeps a sequence number, an instruction class (integer, floating, control), two physical source tags with ready flags, and a destination tag. A scoreboard with one bit per physical register records which values already exist. When an execution unit finishes, it broadcasts the destination tag. Every waiting source that matches the tag becomes ready, and a slot whose sources are all ready raises a request on the request line of its class. An arbiter outside the block picks one ready slot and returns its index on the issue port. That frees the slot.

Each slot is a small state machine with three states. SLOT_EMPTY means the slot is free. SLOT_WAIT means it holds an instruction with at least one source not ready. SLOT_READY means it requests issue. The transitions are these:
- Allocate moves SLOT_EMPTY to SLOT_WAIT, or straight to SLOT_READY when both sources are ready at insert.
- Wakeup moves SLOT_WAIT to SLOT_READY.
- Issue moves SLOT_READY to SLOT_EMPTY.
- Squash moves SLOT_WAIT or SLOT_READY to SLOT_EMPTY when the slot's sequence number is younger than the squash point.

A shared counter tracks the free slots and drives the full flag. An instruction can also bypass the queue. It then only claims its destination register in the scoreboard and takes no slot.

Top module: `issue_queue_wakeup`

## Requirements
- R1: After reset the free count equals DEPTH and no slot is busy. full, ins_err and every request line are low, and every scoreboard bit reads not-ready.
- R2: The free count drops by one for each accepted insert. It rises by one for each issued slot and for each squashed slot. full is high exactly when the count is zero.
- R3: An accepted insert takes the lowest-numbered empty slot, and slot_busy shows that slot from the next cycle.
- R4: An inserted instruction whose two source ready flags are both set requests issue from the next cycle. The request appears on the line of its class: ins_cls 0 drives req_int, 1 drives req_fp, and 2 or 3 drive req_ctl.
- R5: At insert, a source whose ready flag is clear is taken as ready when its scoreboard bit is already set.
- R6: An accepted insert clears the scoreboard bit of its destination tag.
- R7: A completion with a tag below NPREG sets that tag's scoreboard bit and marks ready every waiting source with that tag. A slot whose sources are then all ready requests issue from the next cycle.
- R8: A completion in the same cycle as an insert whose source carries the same tag makes that source ready at insert.
- R9: A completion tag at or above NPREG is ignored. No wakeup happens and no scoreboard bit changes.
- R10: A squash empties every waiting or ready slot whose sequence number is greater than squash_seq. The comparison is unsigned and does not wrap. Slots with a sequence number less than or equal to squash_seq are kept.
- R11: issue_valid with issue_idx naming a ready slot empties that slot. An index naming a slot that is not ready has no effect. A slot issued in the same cycle as a squash that would hit it is counted once, as issued.
- R12: An insert with ins_bypass set takes no slot and never raises ins_err, even when full. It clears the scoreboard bit of its destination.
- R13: An insert without bypass while full is rejected and leaves the slots unchanged. ins_err is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_bypass | input | 1 | Claim destination only, take no slot |
| ins_seq | input | SEQW | Sequence number of the inserted instruction |
| ins_cls | input | 2 | Class: 0 integer, 1 floating, 2/3 control |
| ins_src0 | input | TAGW | Physical tag of source 0 |
| ins_src0_rdy | input | 1 | Source 0 already ready |
| ins_src1 | input | TAGW | Physical tag of source 1 |
| ins_src1_rdy | input | 1 | Source 1 already ready |
| ins_dst | input | TAGW | Physical destination tag |
| done_valid | input | 1 | Completion broadcast valid |
| done_tag | input | TAGW | Completed destination tag |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQW | Squash point; younger unissued slots are flushed |
| issue_valid | input | 1 | Arbiter issues a slot |
| issue_idx | input | IDXW | Index of the issued slot |
| slot_busy | output | DEPTH | Slot holds an instruction |
| req_int | output | DEPTH | Ready integer slots |
| req_fp | output | DEPTH | Ready floating slots |
| req_ctl | output | DEPTH | Ready control slots |
| free_count | output | CNTW | Number of empty slots |
| full | output | 1 | No empty slot |
| ins_err | output | 1 | Rejected insert, one-cycle pulse |

## Verification
The bench builds the block with DEPTH 4, NPREG 8 and SEQW 8. Four slots let a few inserts reach the full state, so rejection and bypass-while-full come within reach. With NPREG 8 the tag is four bits wide. That makes tag 11 legal on the port while it aliases register 3 in its low bits, which exposes any special-register check that truncates the tag. The scoreboard is never read out directly. Its contents are inferred from whether a later consumer waits or requests at once.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

    localparam logic [1:0] CLS_INT = 2'd0;
    localparam logic [1:0] CLS_FP  = 2'd1;
endpackage

// File: rtl/iq_scoreboard.sv
`timescale 1ns/1ps
module iq_scoreboard #(
    parameter int NPREG = 32,
    parameter int TAGW  = $clog2(NPREG) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_v,
    input  logic [TAGW-1:0]  set_tag,
    input  logic             clr_v,
    input  logic [TAGW-1:0]  clr_tag,
    output logic [NPREG-1:0] sb_o
);
    logic [NPREG-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            for (int i = 0; i < NPREG; i++) begin
                if (clr_v && clr_tag == TAGW'(i)) begin
                    bits_q[i] <= 1'b0;
                end else if (set_v && set_tag == TAGW'(i)) begin
                    bits_q[i] <= 1'b1;
                end
            end
        end
    end

    assign sb_o = bits_q;
endmodule

// File: rtl/iq_pick.sv
`timescale 1ns/1ps
module iq_pick #(
    parameter int DEPTH = 8,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] busy_i,
    output logic [IDXW-1:0]  idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                idx_o = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/iq_slot.sv
`timescale 1ns/1ps
module iq_slot
    import iq_pkg::*;
#(
    parameter int SEQW = 8,
    parameter int TAGW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_i,
    input  logic [SEQW-1:0] a_seq,
    input  logic [1:0]      a_cls,
    input  logic [TAGW-1:0] a_src0,
    input  logic            a_rdy0,
    input  logic [TAGW-1:0] a_src1,
    input  logic            a_rdy1,
    input  logic            wake_i,
    input  logic [TAGW-1:0] wake_tag,
    input  logic            kill_req,
    input  logic [SEQW-1:0] kill_seq,
    input  logic            issue_i,
    output logic            busy_o,
    output logic            ready_o,
    output logic [1:0]      cls_o,
    output logic [SEQW-1:0] seq_o,
    output logic            killed_o
);
    slot_state_e     st_q, st_d;
    logic [SEQW-1:0] seq_q;
    logic [1:0]      cls_q;
    logic [TAGW-1:0] src0_q, src1_q;
    logic            r0_q, r1_q;
    logic            m0, m1, both_next, kill, take;

    always_comb begin
        m0        = wake_i && (wake_tag == src0_q);
        m1        = wake_i && (wake_tag == src1_q);
        both_next = (r0_q || m0) && (r1_q || m1);
        take      = issue_i && (st_q == SLOT_READY);
        kill      = kill_req && (st_q != SLOT_EMPTY) && (seq_q > kill_seq) && !take;
        st_d      = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (alloc_i) st_d = (a_rdy0 && a_rdy1) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if (kill) st_d = SLOT_EMPTY;
                        else if (both_next) st_d = SLOT_READY;
            SLOT_READY: if (take || kill) st_d = SLOT_EMPTY;
            default:    st_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SLOT_EMPTY;
            seq_q  <= '0;
            cls_q  <= '0;
            src0_q <= '0;
            src1_q <= '0;
            r0_q   <= 1'b0;
            r1_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == SLOT_EMPTY && alloc_i) begin
                seq_q  <= a_seq;
                cls_q  <= a_cls;
                src0_q <= a_src0;
                src1_q <= a_src1;
                r0_q   <= a_rdy0;
                r1_q   <= a_rdy1;
            end else begin
                r0_q <= r0_q || m0;
                r1_q <= r1_q || m1;
            end
        end
    end

    always_comb begin
        busy_o   = (st_q != SLOT_EMPTY);
        ready_o  = (st_q == SLOT_READY);
        cls_o    = cls_q;
        seq_o    = seq_q;
        killed_o = kill;
    end
endmodule

// File: rtl/issue_queue_wakeup.sv
`timescale 1ns/1ps
module issue_queue_wakeup
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NPREG = 32,
    parameter int SEQW  = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int TAGW = $clog2(NPREG) + 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             ins_bypass,
    input  logic [SEQW-1:0]  ins_seq,
    input  logic [1:0]       ins_cls,
    input  logic [TAGW-1:0]  ins_src0,
    input  logic             ins_src0_rdy,
    input  logic [TAGW-1:0]  ins_src1,
    input  logic             ins_src1_rdy,
    input  logic [TAGW-1:0]  ins_dst,
    input  logic             done_valid,
    input  logic [TAGW-1:0]  done_tag,
    input  logic             squash_valid,
    input  logic [SEQW-1:0]  squash_seq,
    input  logic             issue_valid,
    input  logic [IDXW-1:0]  issue_idx,
    output logic [DEPTH-1:0] slot_busy,
    output logic [DEPTH-1:0] req_int,
    output logic [DEPTH-1:0] req_fp,
    output logic [DEPTH-1:0] req_ctl,
    output logic [CNTW-1:0]  free_count,
    output logic             full,
    output logic             ins_err
);
    logic [NPREG-1:0]            sb_vec;
    logic [DEPTH-1:0]            ready_vec, kill_vec;
    logic [DEPTH-1:0][1:0]       cls_vec;
    logic [DEPTH-1:0][SEQW-1:0]  seq_vec;
    logic [IDXW-1:0]             pick_idx;
    logic [CNTW-1:0]             free_q, nkill;
    logic                        wake_ok, ins_ok, ins_claim, issue_hit, err_q;
    logic                        rdy0_now, rdy1_now;

    function automatic logic src_now(input logic [TAGW-1:0] tag, input logic flag,
                                     input logic [NPREG-1:0] sb, input logic wk,
                                     input logic [TAGW-1:0] wtag);
        if (flag) return 1'b1;
        if (tag >= TAGW'(NPREG)) return 1'b0;
        return sb[tag[TAGW-2:0]] || (wk && wtag == tag);
    endfunction

    always_comb begin
        full      = (free_q == '0);
        wake_ok   = done_valid && (done_tag < TAGW'(NPREG));
        ins_ok    = ins_valid && !ins_bypass && !full;
        ins_claim = ins_ok || (ins_valid && ins_bypass);
        issue_hit = issue_valid && ready_vec[issue_idx];
        rdy0_now  = src_now(ins_src0, ins_src0_rdy, sb_vec, wake_ok, done_tag);
        rdy1_now  = src_now(ins_src1, ins_src1_rdy, sb_vec, wake_ok, done_tag);
        nkill     = '0;
        for (int i = 0; i < DEPTH; i++) nkill = nkill + CNTW'(kill_vec[i]);
    end

    iq_scoreboard #(.NPREG(NPREG), .TAGW(TAGW)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .set_v(wake_ok), .set_tag(done_tag),
        .clr_v(ins_claim), .clr_tag(ins_dst),
        .sb_o(sb_vec)
    );

    iq_pick #(.DEPTH(DEPTH), .IDXW(IDXW)) u_pick (
        .busy_i(slot_busy), .idx_o(pick_idx)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        iq_slot #(.SEQW(SEQW), .TAGW(TAGW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(ins_ok && pick_idx == IDXW'(g)),
            .a_seq(ins_seq), .a_cls(ins_cls),
            .a_src0(ins_src0), .a_rdy0(rdy0_now),
            .a_src1(ins_src1), .a_rdy1(rdy1_now),
            .wake_i(wake_ok), .wake_tag(done_tag),
            .kill_req(squash_valid), .kill_seq(squash_seq),
            .issue_i(issue_valid && issue_idx == IDXW'(g)),
            .busy_o(slot_busy[g]), .ready_o(ready_vec[g]),
            .cls_o(cls_vec[g]), .seq_o(seq_vec[g]), .killed_o(kill_vec[g])
        );
        assign req_int[g] = ready_vec[g] && cls_vec[g] == CLS_INT;
        assign req_fp[g]  = ready_vec[g] && cls_vec[g] == CLS_FP;
        assign req_ctl[g] = ready_vec[g] && cls_vec[g][1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= CNTW'(DEPTH);
            err_q  <= 1'b0;
        end else begin
            free_q <= free_q + CNTW'(issue_hit) + nkill - CNTW'(ins_ok);
            err_q  <= ins_valid && !ins_bypass && full;
        end
    end

    assign free_count = free_q;
    assign ins_err    = err_q;
endmodule

// File: rtl/iq_checker.sv
`timescale 1ns/1ps
module iq_checker #(
    parameter int DEPTH = 8,
    parameter int NPREG = 32,
    parameter int SEQW  = 8,
    localparam int TAGW = $clog2(NPREG) + 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ins_valid,
    input logic                       ins_bypass,
    input logic [TAGW-1:0]            ins_dst,
    input logic                       done_valid,
    input logic [TAGW-1:0]            done_tag,
    input logic                       squash_valid,
    input logic [SEQW-1:0]            squash_seq,
    input logic [DEPTH-1:0]           slot_busy,
    input logic [DEPTH-1:0][SEQW-1:0] seq_vec,
    input logic [NPREG-1:0]           sb_vec,
    input logic [CNTW-1:0]            free_count,
    input logic                       full,
    input logic                       ins_err
);
    logic [SEQW-1:0] sq_q;
    logic [TAGW-1:0] tag_q;
    logic            young_left;

    always_ff @(posedge clk) begin
        sq_q  <= squash_seq;
        tag_q <= done_tag;
    end

    always_comb begin
        young_left = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (slot_busy[i] && seq_vec[i] > sq_q) young_left = 1'b1;
    end

    // R2
    a_r2_free_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        free_count == CNTW'(DEPTH - $countones(slot_busy)));

    // R13
    a_r13_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_bypass && full) |=> ins_err);

    a_r13_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ins_err |-> $past(ins_valid && !ins_bypass && full));

    // R9
    a_r9_special_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_tag >= TAGW'(NPREG) && !ins_valid) |=> $stable(sb_vec));

    // R7
    a_r7_sb_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_tag < TAGW'(NPREG) && !(ins_valid && ins_dst == done_tag))
        |=> sb_vec[tag_q[TAGW-2:0]]);

    // R10
    a_r10_young_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !ins_valid) |=> !young_left);
endmodule

bind issue_queue_wakeup iq_checker #(.DEPTH(DEPTH), .NPREG(NPREG), .SEQW(SEQW)) chk_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_bypass(ins_bypass),
    .ins_dst(ins_dst), .done_valid(done_valid), .done_tag(done_tag),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .slot_busy(slot_busy),
    .seq_vec(seq_vec), .sb_vec(sb_vec), .free_count(free_count), .full(full),
    .ins_err(ins_err)
);

// File: tb/issue_queue_wakeup_tb_top.sv
`timescale 1ns/1ps
module issue_queue_wakeup_tb_top;
    localparam int DEPTH = 4;
    localparam int NPREG = 8;
    localparam int SEQW  = 8;
    localparam int TAGW  = 4;
    localparam int IDXW  = 2;
    localparam int CNTW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid, ins_bypass, ins_src0_rdy, ins_src1_rdy;
    logic [SEQW-1:0] ins_seq, squash_seq;
    logic [1:0] ins_cls;
    logic [TAGW-1:0] ins_src0, ins_src1, ins_dst, done_tag;
    logic done_valid, squash_valid, issue_valid;
    logic [IDXW-1:0] issue_idx;
    logic [DEPTH-1:0] slot_busy, req_int, req_fp, req_ctl;
    logic [CNTW-1:0] free_count;
    logic full, ins_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    issue_queue_wakeup #(.DEPTH(DEPTH), .NPREG(NPREG), .SEQW(SEQW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_bypass(ins_bypass),
        .ins_seq(ins_seq), .ins_cls(ins_cls), .ins_src0(ins_src0),
        .ins_src0_rdy(ins_src0_rdy), .ins_src1(ins_src1), .ins_src1_rdy(ins_src1_rdy),
        .ins_dst(ins_dst), .done_valid(done_valid), .done_tag(done_tag),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .issue_valid(issue_valid), .issue_idx(issue_idx), .slot_busy(slot_busy),
        .req_int(req_int), .req_fp(req_fp), .req_ctl(req_ctl),
        .free_count(free_count), .full(full), .ins_err(ins_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_bypass = 0; ins_seq = 0; ins_cls = 0;
        ins_src0 = 0; ins_src0_rdy = 0; ins_src1 = 0; ins_src1_rdy = 0; ins_dst = 0;
        done_valid = 0; done_tag = 0; squash_valid = 0; squash_seq = 0;
        issue_valid = 0; issue_idx = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic set_ins(int seq, int cls, int s0, bit r0, int s1, bit r1, int dst);
        ins_valid = 1; ins_seq = SEQW'(seq); ins_cls = 2'(cls);
        ins_src0 = TAGW'(s0); ins_src0_rdy = r0; ins_src1 = TAGW'(s1);
        ins_src1_rdy = r1; ins_dst = TAGW'(dst);
    endtask

    task automatic insert(int seq, int cls, int s0, bit r0, int s1, bit r1, int dst);
        set_ins(seq, cls, s0, r0, s1, r1, dst);
        step();
    endtask

    task automatic complete(int tag);
        done_valid = 1; done_tag = TAGW'(tag);
        step();
    endtask

    task automatic squash(int seq);
        squash_valid = 1; squash_seq = SEQW'(seq);
        step();
    endtask

    task automatic issue(int idx);
        issue_valid = 1; issue_idx = IDXW'(idx);
        step();
    endtask

    task automatic flush();
        squash(0);
    endtask

    task automatic t_reset();
        chk("R1", "free_count", free_count, DEPTH);
        chk("R1", "full", full, 0);
        chk("R1", "slot_busy", slot_busy, 0);
        chk("R1", "requests", {req_int, req_fp, req_ctl}, 0);
        chk("R1", "ins_err", ins_err, 0);
        // an unflagged source of any register must wait after reset
        insert(1, 0, 0, 0, 7, 1, 0);
        chk("R1", "scoreboard cleared at reset", req_int, 0);
        flush();
    endtask

    task automatic t_classes();
        insert(10, 0, 1, 1, 2, 1, 1);
        chk("R3", "slot_busy after first insert", slot_busy, 4'b0001);
        chk("R4", "req_int class 0", req_int, 4'b0001);
        chk("R2", "free after one insert", free_count, 3);
        insert(11, 1, 1, 1, 2, 1, 2);
        chk("R4", "req_fp class 1", req_fp, 4'b0010);
        insert(12, 2, 1, 1, 2, 1, 0);
        chk("R4", "req_ctl class 2", req_ctl, 4'b0100);
        insert(13, 3, 1, 1, 2, 1, 0);
        chk("R4", "req_ctl class 3", req_ctl, 4'b1100);
        chk("R2", "full at zero", full, 1);
        chk("R2", "free zero", free_count, 0);
        issue(1);
        chk("R11", "issued slot freed", slot_busy, 4'b1101);
        chk("R2", "free after issue", free_count, 1);
        insert(14, 1, 1, 1, 2, 1, 0);
        chk("R3", "lowest empty slot reused", req_fp, 4'b0010);
        flush();
        chk("R10", "squash 0 empties all", slot_busy, 0);
        chk("R2", "free after flush", free_count, DEPTH);
    endtask

    task automatic t_wake();
        insert(20, 0, 3, 0, 4, 1, 5);
        chk("R7", "waits for source", {slot_busy, req_int}, {4'b0001, 4'b0000});
        issue(0);
        chk("R11", "issue of waiting slot ignored", slot_busy, 4'b0001);
        chk("R11", "free unchanged", free_count, 3);
        complete(3);
        chk("R7", "woken slot requests", req_int, 4'b0001);
        flush();
    endtask

    task automatic t_recheck();
        insert(21, 1, 3, 0, 3, 0, 6);
        chk("R5", "scoreboard recheck at insert", req_fp, 4'b0001);
        flush();
    endtask

    task automatic t_dest_and_special();
        insert(22, 0, 0, 1, 0, 1, 3);
        insert(23, 0, 3, 0, 0, 1, 4);
        chk("R6", "dest claim clears scoreboard", req_int, 4'b0001);
        complete(11);
        chk("R9", "special tag no wakeup", req_int, 4'b0001);
        complete(3);
        chk("R7", "real tag wakes", req_int, 4'b0011);
        flush();
    endtask

    task automatic t_same_cycle();
        set_ins(24, 2, 6, 0, 0, 1, 7);
        done_valid = 1; done_tag = 6;
        step();
        chk("R8", "same-cycle wake seen at insert", req_ctl, 4'b0001);
        insert(25, 2, 6, 0, 0, 1, 0);
        chk("R7", "completion set scoreboard", req_ctl, 4'b0011);
        flush();
    endtask

    task automatic t_squash();
        for (int s = 30; s < 34; s++) insert(s, 0, 5, 0, 0, 1, 0);
        chk("R2", "full after four", full, 1);
        squash(31);
        chk("R10", "younger flushed, older and equal kept", slot_busy, 4'b0011);
        chk("R2", "free after squash", free_count, 2);
        chk("R2", "not full", full, 0);
        complete(5);
        chk("R7", "survivors wake", req_int, 4'b0011);
        flush();
    endtask

    task automatic t_full_and_bypass();
        for (int s = 40; s < 44; s++) insert(s, 0, 2, 0, 0, 1, 0);
        insert(44, 0, 0, 1, 0, 1, 0);
        chk("R13", "err pulse", ins_err, 1);
        chk("R13", "slots unchanged", slot_busy, 4'b1111);
        chk("R13", "free unchanged", free_count, 0);
        step();
        chk("R13", "err one cycle", ins_err, 0);
        complete(7);
        ins_bypass = 1;
        set_ins(0, 0, 0, 1, 0, 1, 7);
        step();
        chk("R12", "bypass no err when full", ins_err, 0);
        chk("R12", "bypass takes no slot", free_count, 0);
        flush();
        insert(45, 1, 7, 0, 0, 1, 0);
        chk("R12", "bypass cleared dest bit", {slot_busy, req_fp}, {4'b0001, 4'b0000});
        flush();
    endtask

    task automatic t_issue_squash();
        insert(50, 0, 0, 1, 0, 1, 0);
        insert(60, 0, 0, 1, 0, 1, 0);
        squash_valid = 1; squash_seq = 40; issue_valid = 1; issue_idx = 0;
        step();
        chk("R11", "issue and squash same cycle", slot_busy, 0);
        chk("R11", "counted once", free_count, DEPTH);
        insert(35, 0, 0, 1, 0, 1, 0);
        insert(36, 0, 2, 0, 0, 1, 0);
        squash(35);
        chk("R10", "equal seq kept", slot_busy, 4'b0001);
        chk("R2", "free after partial squash", free_count, 3);
        flush();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classes();
        t_wake();
        t_recheck();
        t_dest_and_special();
        t_same_cycle();
        t_squash();
        t_full_and_bypass();
        t_issue_squash();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule